// File: doc/BRIEF.md
# Multi-Mode Expansion Bus Master

This block sits between a processor memory port and a 16K-word parallel expansion bus. It turns processor accesses into bus cycles. The processor raises a one-cycle request with an address, a write flag and write data. The block decodes the address into one of three 64 KB windows or one control register, runs the bus cycle, and returns a one-cycle acknowledge with any read data.

Each window picks a cycle type. The slow window always runs a long fixed-length data cycle. The fast window runs a short fixed-length data cycle. When the page-enable bit in the control register is set, writes to the fast window instead become address-strobe cycles: the write data is driven on the bus data lines as a page number that the slave latches. Reads in that window stay ordinary fast data reads. The handshake window keeps the data strobe asserted until the slave pulls its active-low ready line down. A timeout limits how long it waits, and when the timeout ends a cycle the block sets a sticky error flag.

Top module: `xbus_master`

## Requirements
- R1: After reset both strobes are high, the acknowledge is low, and the control register reads 0.
- R2: An access with address bits [31:16] = 0x0160 holds the data strobe low for exactly STD_LEN clocks, whatever the page-enable bit holds.
- R3: An access with address bits [31:16] = 0x0164 while page-enable is 0 holds the data strobe low for exactly FAST_LEN clocks.
- R4: A write with address bits [31:16] = 0x0164 while page-enable is 1 holds the address strobe low for exactly FAST_LEN clocks. The data strobe stays high, and bus_dout carries write data bits [13:0] zero-extended. The two strobes are never low together.
- R5: A read with address bits [31:16] = 0x0164 while page-enable is 1 is an ordinary FAST_LEN data-strobe read.
- R6: An access with address bits [31:16] = 0x0168 holds the data strobe low until bus_rdy_n is sampled low at a rising edge, and ends the strobe at that edge.
- R7: If bus_rdy_n is still high after TMO_LEN strobe clocks, the handshake cycle ends and control bit 2 (error) is set. The bit stays set until a register write with bit 2 = 1 clears it.
- R8: The acknowledge is a single-clock pulse that comes one clock after the strobe goes high. Read data equals bus_din as sampled at the edge that ends the strobe.
- R9: The control register sits at byte address 0x016D_8018. Bit 1 is page-enable and can be read and written. A register read returns {error at bit 2, page-enable at bit 1}, and the acknowledge comes one clock after the request.
- R10: While a strobe is low, bus_addr equals address bits [15:2], and bus_rw is 1 for reads and 0 for writes. During writes bus_dout_en is 1.
- R11: An access to any other address asserts no strobe, is acknowledged one clock after the request, and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-clock access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | DW | Write data |
| cpu_ack | output | 1 | One-clock completion pulse |
| cpu_rdata | output | DW | Read data, valid with cpu_ack |
| bus_addr | output | BA_W | Bus word address |
| bus_dout | output | DW | Bus data driven by the master |
| bus_dout_en | output | 1 | Master drives the data lines |
| bus_din | input | DW | Bus data driven by the slave |
| bus_dstrb_n | output | 1 | Active-low data strobe |
| bus_astrb_n | output | 1 | Active-low page-address strobe |
| bus_rdy_n | input | 1 | Active-low slave ready |
| bus_rw | output | 1 | 1 = read, 0 = write |

## Verification
Each window is exercised with both reads and writes, with page-enable both clear and set. This separates the slow, fast and page-strobe cycle types by strobe length and by which strobe toggles. It also shows that the slow window ignores the enable bit. The handshake window is driven by a slave that answers after one clock, after a few clocks, exactly at the timeout limit, and never. These four cases separate ready termination from timeout and show where the error flag is set, read back and cleared. Register and unmapped accesses confirm the short acknowledge path and show that no strobe is raised.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      XM_NONE = 3'd0,
      XM_STD  = 3'd1,
      XM_FAST = 3'd2,
      XM_PAGE = 3'd3,
      XM_RDY  = 3'd4,
      XM_REG  = 3'd5
   } xmode_e;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_STRB = 2'd1,
      XS_GAP  = 2'd2,
      XS_ACK  = 2'd3
   } xstate_e;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
   import xbus_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int          WIN_LG2  = 16,
   parameter logic [31:0] STD_BASE = 32'h0160_0000,
   parameter logic [31:0] FST_BASE = 32'h0164_0000,
   parameter logic [31:0] RDY_BASE = 32'h0168_0000,
   parameter logic [31:0] REG_ADDR = 32'h016D_8018
) (
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic          page_en,
   output xmode_e        mode
);
   localparam int TW = AW - WIN_LG2;

   generate
      if (WIN_LG2 < 1 || WIN_LG2 >= AW) begin : g_bad_win
         $error("xbus_decode: WIN_LG2 out of range");
      end
   endgenerate

   logic [TW-1:0] tag;
   logic          hit_std, hit_fst, hit_rdy, hit_reg;

   assign tag     = addr[AW-1:WIN_LG2];
   assign hit_std = (tag == STD_BASE[AW-1:WIN_LG2]);
   assign hit_fst = (tag == FST_BASE[AW-1:WIN_LG2]);
   assign hit_rdy = (tag == RDY_BASE[AW-1:WIN_LG2]);
   assign hit_reg = (addr == REG_ADDR[AW-1:0]);

   always_comb begin
      mode = XM_NONE;
      if (hit_reg)
         mode = XM_REG;
      else if (hit_std)
         mode = XM_STD;
      else if (hit_fst)
         mode = (page_en && we) ? XM_PAGE : XM_FAST;
      else if (hit_rdy)
         mode = XM_RDY;
   end
endmodule

// File: rtl/xbus_ctrl_reg.sv
module xbus_ctrl_reg #(
   parameter int DW      = 32,
   parameter int EN_BIT  = 1,
   parameter int ERR_BIT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          err_set,
   output logic          page_en,
   output logic [DW-1:0] value
);
   generate
      if (EN_BIT == ERR_BIT || EN_BIT >= DW || ERR_BIT >= DW) begin : g_bad_bits
         $error("xbus_ctrl_reg: bit positions invalid");
      end
   endgenerate

   logic en_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (wr)
            en_q <= wdata[EN_BIT];
         if (err_set)
            err_q <= 1'b1;
         else if (wr && wdata[ERR_BIT])
            err_q <= 1'b0;
      end
   end

   always_comb begin
      value          = '0;
      value[EN_BIT]  = en_q;
      value[ERR_BIT] = err_q;
   end

   assign page_en = en_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(wr && wdata[ERR_BIT])) |=> err_q); // R7
   AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(err_set)); // R7
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int DW       = 32,
   parameter int BA_W     = 14,
   parameter int PAGE_W   = 14,
   parameter int STD_LEN  = 6,
   parameter int FAST_LEN = 3,
   parameter int TMO_LEN  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  xmode_e          mode,
   input  logic            we,
   input  logic [BA_W-1:0] waddr,
   input  logic [DW-1:0]   wdata,
   input  logic [DW-1:0]   reg_val,
   input  logic [DW-1:0]   bus_din,
   input  logic            bus_rdy_n,
   output logic            idle,
   output logic            err_set,
   output logic [BA_W-1:0] bus_addr,
   output logic [DW-1:0]   bus_dout,
   output logic            bus_dout_en,
   output logic            bus_dstrb_n,
   output logic            bus_astrb_n,
   output logic            bus_rw,
   output logic            cpu_ack,
   output logic [DW-1:0]   cpu_rdata
);
   localparam int MAXC = (STD_LEN > TMO_LEN) ? STD_LEN : TMO_LEN;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (FAST_LEN < 1 || STD_LEN <= FAST_LEN) begin : g_bad_len
         $error("xbus_seq: need STD_LEN > FAST_LEN >= 1");
      end
      if (TMO_LEN < 1) begin : g_bad_tmo
         $error("xbus_seq: TMO_LEN must be at least 1");
      end
      if (PAGE_W > DW) begin : g_bad_page
         $error("xbus_seq: PAGE_W exceeds DW");
      end
   endgenerate

   xstate_e         st_q;
   xmode_e          mode_q;
   logic            we_q;
   logic [BA_W-1:0] addr_q;
   logic [DW-1:0]   wdata_q;
   logic [DW-1:0]   rdata_q;
   logic [CW-1:0]   cnt_q;
   logic            strb_end;
   logic            on_bus;
   logic [DW-1:0]   page_word;

   generate
      if (DW > PAGE_W) begin : g_page_ext
         assign page_word = {{(DW-PAGE_W){1'b0}}, wdata_q[PAGE_W-1:0]};
      end else begin : g_page_full
         assign page_word = wdata_q;
      end
   endgenerate

   always_comb begin
      if (mode_q == XM_RDY)
         strb_end = !bus_rdy_n || (cnt_q == '0);
      else
         strb_end = (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= XS_IDLE;
         mode_q  <= XM_NONE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         cnt_q   <= '0;
      end else begin
         case (st_q)
            XS_IDLE: begin
               if (start) begin
                  mode_q  <= mode;
                  we_q    <= we;
                  addr_q  <= waddr;
                  wdata_q <= wdata;
                  case (mode)
                     XM_STD: begin
                        cnt_q <= CW'(STD_LEN - 1);
                        st_q  <= XS_STRB;
                     end
                     XM_FAST, XM_PAGE: begin
                        cnt_q <= CW'(FAST_LEN - 1);
                        st_q  <= XS_STRB;
                     end
                     XM_RDY: begin
                        cnt_q <= CW'(TMO_LEN - 1);
                        st_q  <= XS_STRB;
                     end
                     default: begin
                        rdata_q <= (mode == XM_REG && !we) ? reg_val : '0;
                        st_q    <= XS_ACK;
                     end
                  endcase
               end
            end
            XS_STRB: begin
               if (strb_end) begin
                  st_q <= XS_GAP;
                  rdata_q <= we_q ? '0 : bus_din;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            XS_GAP:  st_q <= XS_ACK;
            default: st_q <= XS_IDLE;
         endcase
      end
   end

   assign on_bus      = (st_q == XS_STRB) || (st_q == XS_GAP);
   assign idle        = (st_q == XS_IDLE);
   assign err_set     = (st_q == XS_STRB) && (mode_q == XM_RDY) && bus_rdy_n && (cnt_q == '0);
   assign bus_addr    = addr_q;
   assign bus_dout    = (mode_q == XM_PAGE) ? page_word : wdata_q;
   assign bus_dout_en = on_bus && we_q;
   assign bus_rw      = !(on_bus && we_q);
   assign bus_dstrb_n = !((st_q == XS_STRB) && (mode_q != XM_PAGE));
   assign bus_astrb_n = !((st_q == XS_STRB) && (mode_q == XM_PAGE));
   assign cpu_ack     = (st_q == XS_ACK);
   assign cpu_rdata   = rdata_q;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_dstrb_n && !bus_astrb_n)); // R4
   AST_PAGE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_astrb_n |-> (!bus_rw && bus_dout_en)); // R4
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack); // R8
   AST_ACK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> ($past(bus_dstrb_n) && $past(bus_astrb_n))); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_dstrb_n && $past(!bus_dstrb_n)) |-> $stable(bus_addr)); // R10
endmodule

// File: rtl/xbus_master.sv
module xbus_master
   import xbus_pkg::*;
#(
   parameter int          DW       = 32,
   parameter int          BA_W     = 14,
   parameter int          PAGE_W   = 14,
   parameter int          STD_LEN  = 6,
   parameter int          FAST_LEN = 3,
   parameter int          TMO_LEN  = 8,
   parameter logic [31:0] STD_BASE = 32'h0160_0000,
   parameter logic [31:0] FST_BASE = 32'h0164_0000,
   parameter logic [31:0] RDY_BASE = 32'h0168_0000,
   parameter logic [31:0] REG_ADDR = 32'h016D_8018
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic [31:0]     cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic            cpu_ack,
   output logic [DW-1:0]   cpu_rdata,
   output logic [BA_W-1:0] bus_addr,
   output logic [DW-1:0]   bus_dout,
   output logic            bus_dout_en,
   input  logic [DW-1:0]   bus_din,
   output logic            bus_dstrb_n,
   output logic            bus_astrb_n,
   input  logic            bus_rdy_n,
   output logic            bus_rw
);
   localparam int WORD_LG2 = 2;
   localparam int WIN_LG2  = BA_W + WORD_LG2;

   generate
      if (DW < 3) begin : g_bad_dw
         $error("xbus_master: DW too small for control bits");
      end
      if (WIN_LG2 >= 32) begin : g_bad_ba
         $error("xbus_master: BA_W too large");
      end
   endgenerate

   xmode_e          mode;
   logic            page_en;
   logic [DW-1:0]   reg_val;
   logic            seq_idle;
   logic            start;
   logic            reg_wr;
   logic            err_set;

   assign start  = cpu_req && seq_idle;
   assign reg_wr = start && (mode == XM_REG) && cpu_we;

   xbus_decode #(
      .AW       (32),
      .WIN_LG2  (WIN_LG2),
      .STD_BASE (STD_BASE),
      .FST_BASE (FST_BASE),
      .RDY_BASE (RDY_BASE),
      .REG_ADDR (REG_ADDR)
   ) decode_i (
      .addr    (cpu_addr),
      .we      (cpu_we),
      .page_en (page_en),
      .mode    (mode)
   );

   xbus_ctrl_reg #(
      .DW      (DW),
      .EN_BIT  (1),
      .ERR_BIT (2)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wdata   (cpu_wdata),
      .err_set (err_set),
      .page_en (page_en),
      .value   (reg_val)
   );

   xbus_seq #(
      .DW       (DW),
      .BA_W     (BA_W),
      .PAGE_W   (PAGE_W),
      .STD_LEN  (STD_LEN),
      .FAST_LEN (FAST_LEN),
      .TMO_LEN  (TMO_LEN)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode        (mode),
      .we          (cpu_we),
      .waddr       (cpu_addr[WIN_LG2-1:WORD_LG2]),
      .wdata       (cpu_wdata),
      .reg_val     (reg_val),
      .bus_din     (bus_din),
      .bus_rdy_n   (bus_rdy_n),
      .idle        (seq_idle),
      .err_set     (err_set),
      .bus_addr    (bus_addr),
      .bus_dout    (bus_dout),
      .bus_dout_en (bus_dout_en),
      .bus_dstrb_n (bus_dstrb_n),
      .bus_astrb_n (bus_astrb_n),
      .bus_rw      (bus_rw),
      .cpu_ack     (cpu_ack),
      .cpu_rdata   (cpu_rdata)
   );

   AST_REG_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == XM_REG || mode == XM_NONE)) |=> (bus_dstrb_n && bus_astrb_n && cpu_ack)); // R11
   AST_STD_IGNORES_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cpu_addr[31:WIN_LG2] == STD_BASE[31:WIN_LG2]) |=> !bus_dstrb_n); // R2
endmodule

// File: tb/xbus_master_tb_top.sv
module xbus_master_tb_top;
   localparam int DW   = 32;
   localparam int BA_W = 14;
   localparam int STDL = 6;
   localparam int FSTL = 3;
   localparam int TMOL = 8;
   localparam int K_NONE = 0, K_STD = 1, K_FAST = 2, K_PAGE = 3, K_RDY = 4, K_REG = 5;
   localparam logic [31:0] A_REG = 32'h016D_8018;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0]     cpu_addr = '0;
   logic [DW-1:0]   cpu_wdata = '0;
   logic            cpu_ack;
   logic [DW-1:0]   cpu_rdata;
   logic [BA_W-1:0] bus_addr;
   logic [DW-1:0]   bus_dout;
   logic            bus_dout_en;
   logic [DW-1:0]   bus_din = '0;
   logic            bus_dstrb_n, bus_astrb_n, bus_rw;
   logic            bus_rdy_n = 1'b1;

   int n_tests = 0, n_fail = 0;
   int rdy_wait = 1000000;
   int slv_cnt = 0;
   int cyc = 0;
   bit done = 0;

   // reference model state
   bit          m_busy = 0, m_en = 0, m_err = 0, m_tmo = 0, m_we = 0;
   int          m_t = 0, m_L = 0, m_kind = 0;
   logic [31:0] m_addr = '0, m_wdata = '0, m_rexp = '0;

   always #4 clk = ~clk;

   xbus_master #(.DW(DW), .BA_W(BA_W), .PAGE_W(14), .STD_LEN(STDL),
                 .FAST_LEN(FSTL), .TMO_LEN(TMOL)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
      .cpu_rdata(cpu_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_dstrb_n(bus_dstrb_n),
      .bus_astrb_n(bus_astrb_n), .bus_rdy_n(bus_rdy_n), .bus_rw(bus_rw));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic int kind_of(input logic [31:0] a, input bit we, input bit en);
      if (a == A_REG) return K_REG;
      case (a[31:16])
         16'h0160: return K_STD;
         16'h0164: return (en && we) ? K_PAGE : K_FAST;
         16'h0168: return K_RDY;
         default:  return K_NONE;
      endcase
   endfunction

   function automatic string tag_of(input int k, input bit we, input bit en, input bit tmo);
      case (k)
         K_STD:  return "R2";
         K_FAST: return (en && !we) ? "R5" : "R3";
         K_PAGE: return "R4";
         K_RDY:  return tmo ? "R7" : "R6";
         K_REG:  return "R9";
         default: return "R11";
      endcase
   endfunction

   // slave ready responder
   always @(negedge clk) begin
      if (!bus_dstrb_n) slv_cnt = slv_cnt + 1;
      else slv_cnt = 0;
      bus_rdy_n = !(slv_cnt > 0 && slv_cnt >= rdy_wait);
   end

   // behavioural reference model
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_en = 0; m_err = 0;
      end else if (m_busy) begin
         if (m_t == m_L && m_tmo) m_err = 1;
         if (m_t == m_L + 2) m_busy = 0;
         else m_t++;
      end else if (cpu_req) begin
         m_busy = 1; m_t = 1; m_we = cpu_we; m_addr = cpu_addr; m_wdata = cpu_wdata;
         m_kind = kind_of(cpu_addr, cpu_we, m_en);
         m_tmo = 0; m_rexp = '0;
         case (m_kind)
            K_STD:  m_L = STDL;
            K_FAST, K_PAGE: m_L = FSTL;
            K_RDY: begin
               m_L = (rdy_wait <= TMOL) ? rdy_wait : TMOL;
               m_tmo = (rdy_wait > TMOL);
            end
            default: m_L = -1;
         endcase
         if (m_kind == K_REG) begin
            m_rexp = {29'd0, m_err, m_en, 1'b0};
            if (cpu_we) begin
               m_en = cpu_wdata[1];
               if (cpu_wdata[2]) m_err = 0;
               m_rexp = '0;
            end
         end else if (m_kind != K_NONE && !cpu_we) begin
            m_rexp = bus_din;
         end
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit    son, eack;
         string tg;
         son  = m_busy && m_t >= 1 && m_t <= m_L;
         eack = m_busy && m_t == m_L + 2;
         tg   = tag_of(m_kind, m_we, m_en, m_tmo);
         chk(bus_dstrb_n == !(son && m_kind != K_PAGE), tg, 32'(bus_dstrb_n), 32'(!(son && m_kind != K_PAGE)));
         chk(bus_astrb_n == !(son && m_kind == K_PAGE), tg, 32'(bus_astrb_n), 32'(!(son && m_kind == K_PAGE)));
         chk(cpu_ack == eack, eack ? "R8" : tg, 32'(cpu_ack), 32'(eack));
         if (son) begin
            chk(bus_addr == m_addr[15:2], "R10", 32'(bus_addr), 32'(m_addr[15:2]));
            chk(bus_rw == !m_we, "R10", 32'(bus_rw), 32'(!m_we));
            if (m_we) begin
               logic [31:0] ed;
               ed = (m_kind == K_PAGE) ? {18'd0, m_wdata[13:0]} : m_wdata;
               chk(bus_dout_en === 1'b1, "R10", 32'(bus_dout_en), 32'd1);
               chk(bus_dout == ed, tg, bus_dout, ed);
            end
         end
         if (eack && !m_we)
            chk(cpu_rdata == m_rexp, (m_kind == K_REG || m_kind == K_NONE) ? tg : "R8", cpu_rdata, m_rexp);
      end
   end

   task automatic acc(input logic [31:0] a, input bit we, input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_req = 1'b1;
      @(negedge clk);
      cpu_req = 1'b0;
      while (!cpu_ack) @(negedge clk);
      rd = cpu_rdata;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      chk(bus_dstrb_n && bus_astrb_n, "R1", {bus_dstrb_n, bus_astrb_n}, 32'd3);
      chk(!cpu_ack, "R1", 32'(cpu_ack), 32'd0);
      rst_n = 1'b1;
      acc(A_REG, 0, 0, rd);
      chk(rd == 0, "R1", rd, 0);
      acc(32'h0160_0040, 1, 32'hDEAD_0001, rd);
      bus_din = 32'h1234_5678;
      acc(32'h0160_0104, 0, 0, rd);
      chk(rd == 32'h1234_5678, "R2", rd, 32'h1234_5678);
      acc(32'h0164_FFFC, 1, 32'hCAFE_0002, rd);
      bus_din = 32'h0BAD_F00D;
      acc(32'h0164_0008, 0, 0, rd);
      acc(A_REG, 1, 32'h2, rd);
      acc(A_REG, 0, 0, rd);
      chk(rd == 32'h2, "R9", rd, 32'h2);
      acc(32'h0164_0010, 1, 32'hFFFF_ABCD, rd);
      bus_din = 32'h5555_AAAA;
      acc(32'h0164_0020, 0, 0, rd);
      chk(rd == 32'h5555_AAAA, "R5", rd, 32'h5555_AAAA);
      acc(32'h0160_0080, 1, 32'h0000_0077, rd);
      rdy_wait = 4; bus_din = 32'h0000_4444;
      acc(32'h0168_0030, 0, 0, rd);
      chk(rd == 32'h0000_4444, "R6", rd, 32'h4444);
      rdy_wait = 1;
      acc(32'h0168_0034, 1, 32'h0101_0101, rd);
      rdy_wait = TMOL;
      acc(32'h0168_0038, 0, 0, rd);
      acc(A_REG, 0, 0, rd);
      chk(rd[2] == 1'b0, "R6", rd, 32'h2);
      rdy_wait = 1000000;
      acc(32'h0168_003C, 0, 0, rd);
      acc(A_REG, 0, 0, rd);
      chk(rd == 32'h6, "R7", rd, 32'h6);
      acc(32'h0160_0000, 0, 0, rd);
      acc(A_REG, 0, 0, rd);
      chk(rd == 32'h6, "R7", rd, 32'h6);
      acc(A_REG, 1, 32'h6, rd);
      acc(A_REG, 0, 0, rd);
      chk(rd == 32'h2, "R7", rd, 32'h2);
      acc(A_REG, 1, 32'h0, rd);
      acc(32'h0164_0044, 1, 32'h0000_1111, rd);
      bus_din = 32'hFFFF_FFFF;
      acc(32'h0170_0000, 0, 0, rd);
      chk(rd == 0, "R11", rd, 0);
      acc(32'h016D_801C, 1, 32'h6, rd);
      acc(A_REG, 0, 0, rd);
      chk(rd == 0, "R11", rd, 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule